// File: doc/BRIEF.md
# SDRAM Refresh Request Timer

This block paces the refresh traffic of an SDRAM controller. It counts bus clock cycles and, each time the selected refresh interval has passed, raises a request toward the controller's command sequencer. A two-bit rate field picks one of three intervals or turns refresh off. The interval's cycle count follows from a two-bit bus frequency select, because the timer runs on the bus clock.

The sequencer answers each refresh it performs with a one-cycle acknowledge. Intervals that expire before the sequencer catches up are not lost. They build up in a pending count, capped at eight, and the request stays high until every pending refresh has been acknowledged. Any change of the rate or frequency setting restarts the interval from zero. The block only produces requests. It issues no SDRAM commands and does not arbitrate against normal accesses.

Top module: `refresh_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `refReq` is 0 and `pendCount` is 0.
- R2: With `rateSel` = 2'b00 the interval counter stays at zero, no expiry takes place, and `pendCount` never rises, whatever its value was.
- R3: Interval length in cycles is floor(tenths of a µs × MHz / 10). `rateSel` 2'b01 is 7.8 µs, 2'b10 is 15.6 µs and 2'b11 is 125 µs. `freqSel` 2'b00 is 66 MHz, 2'b01 is 100 MHz, and both 2'b10 and 2'b11 are 133 MHz. For example, 7.8 µs at 66 MHz is 514 cycles. The first expiry is counted at the clock edge that lies that many edges after the edge that captured the setting.
- R4: While a setting stays unchanged, expiries repeat every interval, whether or not the requests are acknowledged.
- R5: A change of `rateSel` or `freqSel`, seen at a clock edge, restarts the interval count from zero at that edge. The partly elapsed interval of the old setting never expires.
- R6: Each expiry with no effective acknowledge on the same edge raises `pendCount` by one, up to a ceiling of 8. Further expiries leave it at 8.
- R7: An acknowledge (`refAck` high at an edge) lowers a nonzero `pendCount` by one. An acknowledge while `pendCount` is 0 is ignored. An acknowledge and an expiry on the same edge leave `pendCount` unchanged.
- R8: `refReq` is high exactly when `pendCount` is nonzero, so it falls on the edge that takes the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock that the interval is counted in |
| rstN | input | 1 | Asynchronous reset, active low |
| rateSel | input | 2 | Refresh interval select; 2'b00 turns refresh off |
| freqSel | input | 2 | Bus clock frequency select for the cycle count |
| refAck | input | 1 | Sequencer has performed one refresh |
| refReq | output | 1 | Refresh wanted; high while refreshes are pending |
| pendCount | output | 4 | Number of refreshes owed, 0 to 8 |

## Verification
Every result here is a register one edge downstream of its cause. An expiry lands on `pendCount` at the edge that lies exactly one interval after the edge that captured the setting. An acknowledge shows at the edge that sampled it. The bench drives inputs on falling edges and numbers the rising edges. For each expected count it computes the due edge from the interval formula and queues it. The monitor compares at the falling edge right after that rising edge, and also one edge earlier for each first expiry, so an off-by-one interval shows up.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

  // Command strobes from the control to the interval datapath.
  typedef struct packed {
    logic clear;  // force the interval count back to zero
    logic run;    // advance the interval count this cycle
  } cntCmd_t;

  // Interval length in bus cycles for an interval given in tenths of a microsecond.
  function automatic int tcCycles(input int tenthsUs, input int mhz);
    return (tenthsUs * mhz) / 10;
  endfunction

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/refresh_interval_dp.sv
module refresh_interval_dp
  import refresh_timer_pkg::*;
#(
  parameter int FREQ_LO_MHZ    = 66,
  parameter int FREQ_MID_MHZ   = 100,
  parameter int FREQ_HI_MHZ    = 133,
  parameter int SHORT_TENTH_US = 78,
  parameter int MID_TENTH_US   = 156,
  parameter int LONG_TENTH_US  = 1250,
  parameter int CNT_W          = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntCmd_t    cmd,
  input  logic [1:0] heldRate,
  input  logic [1:0] heldFreq,
  output logic       expire
);

  localparam int N_CODES = 4;

  logic [CNT_W-1:0] tcTab [N_CODES*N_CODES];
  logic [CNT_W-1:0] termCount;
  logic [CNT_W-1:0] cnt;
  logic             atEnd;

  // Terminal-count table indexed by {frequency code, rate code}.
  for (genvar f = 0; f < N_CODES; f++) begin : g_freq
    localparam int MHZ = (f == 0) ? FREQ_LO_MHZ :
                         (f == 1) ? FREQ_MID_MHZ : FREQ_HI_MHZ;
    for (genvar r = 0; r < N_CODES; r++) begin : g_rate
      localparam int TENTHS = (r == 1) ? SHORT_TENTH_US :
                              (r == 2) ? MID_TENTH_US  :
                              (r == 3) ? LONG_TENTH_US : 0;
      assign tcTab[f*N_CODES + r] = CNT_W'(tcCycles(TENTHS, MHZ));
    end
  end

  assign termCount = tcTab[{heldFreq, heldRate}];
  assign atEnd     = (cnt == termCount - 1'b1);
  assign expire    = cmd.run && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.clear) begin
      cnt <= '0;
    end else if (cmd.run) begin
      cnt <= atEnd ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_timer_pkg::*;
#(
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        rateSel,
  input  logic [1:0]        freqSel,
  input  logic              refAck,
  input  logic              expire,
  output cntCmd_t           cmd,
  output logic [1:0]        heldRate,
  output logic [1:0]        heldFreq,
  output logic              refReq,
  output logic [PEND_W-1:0] pendCount
);

  localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(PEND_MAX);

  logic              settingChanged;
  logic              ackTaken;
  logic [PEND_W-1:0] pend;

  // Settings capture: a difference from the held copy restarts the interval.
  assign settingChanged = ({rateSel, freqSel} != {heldRate, heldFreq});

  always_comb begin
    cmd.clear = settingChanged || (heldRate == 2'b00);
    cmd.run   = !cmd.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldRate <= 2'b00;
      heldFreq <= 2'b00;
    end else if (settingChanged) begin
      heldRate <= rateSel;
      heldFreq <= freqSel;
    end
  end

  // Pending refresh count, saturating at PEND_MAX.
  assign ackTaken = refAck && (pend != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      unique case ({expire, ackTaken})
        2'b10:   if (pend != PEND_TOP) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign pendCount = pend;
  assign refReq    = (pend != '0);

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import refresh_timer_pkg::*;
#(
  parameter int FREQ_LO_MHZ    = 66,
  parameter int FREQ_MID_MHZ   = 100,
  parameter int FREQ_HI_MHZ    = 133,
  parameter int SHORT_TENTH_US = 78,
  parameter int MID_TENTH_US   = 156,
  parameter int LONG_TENTH_US  = 1250,
  parameter int PEND_MAX       = 8,
  localparam int MAX_TC = tcCycles(LONG_TENTH_US,
                                   maxOf3(FREQ_LO_MHZ, FREQ_MID_MHZ, FREQ_HI_MHZ)),
  localparam int CNT_W  = $clog2(MAX_TC + 1),
  localparam int PEND_W = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        rateSel,
  input  logic [1:0]        freqSel,
  input  logic              refAck,
  output logic              refReq,
  output logic [PEND_W-1:0] pendCount
);

  cntCmd_t    cmd;
  logic       expire;
  logic [1:0] heldRate;
  logic [1:0] heldFreq;

  refresh_ctrl #(
    .PEND_MAX(PEND_MAX),
    .PEND_W  (PEND_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rateSel  (rateSel),
    .freqSel  (freqSel),
    .refAck   (refAck),
    .expire   (expire),
    .cmd      (cmd),
    .heldRate (heldRate),
    .heldFreq (heldFreq),
    .refReq   (refReq),
    .pendCount(pendCount)
  );

  refresh_interval_dp #(
    .FREQ_LO_MHZ   (FREQ_LO_MHZ),
    .FREQ_MID_MHZ  (FREQ_MID_MHZ),
    .FREQ_HI_MHZ   (FREQ_HI_MHZ),
    .SHORT_TENTH_US(SHORT_TENTH_US),
    .MID_TENTH_US  (MID_TENTH_US),
    .LONG_TENTH_US (LONG_TENTH_US),
    .CNT_W         (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .heldRate(heldRate),
    .heldFreq(heldFreq),
    .expire  (expire)
  );

endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk #(
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        rateSel,
  input logic              refAck,
  input logic              refReq,
  input logic [PEND_W-1:0] pendCount
);

  a_r6_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_W'(PEND_MAX));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pendCount) <= int'($past(pendCount)) + 1) &&
    (int'(pendCount) + 1 >= int'($past(pendCount))));

  a_r6_saturated_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == PEND_W'(PEND_MAX)) && !refAck |=> pendCount == PEND_W'(PEND_MAX));

  a_r2_off_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == 2'b00) |=> pendCount <= $past(pendCount));

  a_r7_ack_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    refAck && (pendCount != '0) |=> pendCount <= $past(pendCount));

  a_r8_rise_from_one: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refReq) |-> pendCount == 1);

  a_r8_fall_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refReq) |-> ($past(pendCount) == 1) && $past(refAck));

endmodule

bind refresh_timer refresh_timer_chk #(
  .PEND_MAX(PEND_MAX),
  .PEND_W  (PEND_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rateSel  (rateSel),
  .refAck   (refAck),
  .refReq   (refReq),
  .pendCount(pendCount)
);

// File: tb/refresh_timer_bench.sv
module refresh_timer_bench;

  typedef struct {
    int    edgeNo;
    int    pend;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rateSel = 2'b00;
  logic [1:0] freqSel = 2'b00;
  logic       refAck = 1'b0;
  logic       refReq;
  logic [3:0] pendCount;

  int       cyc = 0;
  int       nRun = 0;
  int       nFail = 0;
  bit       finished = 1'b0;
  expItem_t q[$];

  refresh_timer u_refresh_timer (
    .clk      (clk),
    .rstN     (rstN),
    .rateSel  (rateSel),
    .freqSel  (freqSel),
    .refAck   (refAck),
    .refReq   (refReq),
    .pendCount(pendCount)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cyclesFor(int tenthsUs, int mhz);
    return (tenthsUs * mhz) / 10;
  endfunction

  task automatic expectAt(int e, int p, string tag);
    expItem_t it;
    it.edgeNo = e;
    it.pend   = p;
    it.tag    = tag;
    q.push_back(it);
  endtask

  // Leaves the bench at the falling edge before rising edge e, so inputs set now are sampled at e.
  task automatic gotoEdge(int e);
    while (cyc < e - 1) @(negedge clk);
  endtask

  // Monitor: compare due items at the falling edge after their rising edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].edgeNo <= cyc) begin
      expItem_t it;
      it = q.pop_front();
      nRun++;
      if (it.edgeNo != cyc) begin
        nFail++;
        $display("FAIL %s: check for edge %0d missed (now %0d)", it.tag, it.edgeNo, cyc);
      end else if (pendCount !== 4'(it.pend) || refReq !== (it.pend != 0)) begin
        nFail++;
        $display("FAIL %s @%0d: pendCount=%0d refReq=%0b expected pendCount=%0d refReq=%0b",
                 it.tag, cyc, pendCount, refReq, it.pend, (it.pend != 0));
      end
    end
  end

  initial begin
    int t1, t2, t3, t4, c0, c1, c2, c3, c4;
    t1 = cyclesFor(78, 66);     // 514
    t2 = cyclesFor(156, 100);   // 1560
    t3 = cyclesFor(156, 133);   // 2074
    t4 = cyclesFor(1250, 133);  // 16625

    // R1: reset state, during and right after reset
    expectAt(2, 0, "R1");
    expectAt(4, 0, "R1");
    gotoEdge(4);
    rstN = 1'b1;

    // R2: refresh off, nothing happens
    expectAt(300, 0, "R2");

    // R3, R4, R6: 7.8 us at 66 MHz, no acknowledge
    c0 = 400;
    gotoEdge(c0);
    rateSel = 2'b01;
    freqSel = 2'b00;
    expectAt(c0 + t1 - 1, 0, "R3");
    expectAt(c0 + t1, 1, "R3");
    expectAt(c0 + 2*t1 - 1, 1, "R4");
    expectAt(c0 + 2*t1, 2, "R4");
    expectAt(c0 + 8*t1, 8, "R6");
    expectAt(c0 + 9*t1, 8, "R6");

    // R7: single acknowledge lowers the count
    expectAt(c0 + 9*t1 + 5, 7, "R7");
    gotoEdge(c0 + 9*t1 + 5);
    refAck = 1'b1;
    gotoEdge(c0 + 9*t1 + 6);
    refAck = 1'b0;

    // R7 same-edge ack and expiry, R8 drain to zero, R7 ignored ack at zero
    expectAt(c0 + 10*t1, 7, "R7");
    expectAt(c0 + 10*t1 + 6, 1, "R8");
    expectAt(c0 + 10*t1 + 7, 0, "R8");
    expectAt(c0 + 10*t1 + 8, 0, "R7");
    gotoEdge(c0 + 10*t1);
    refAck = 1'b1;
    gotoEdge(c0 + 10*t1 + 9);
    refAck = 1'b0;
    expectAt(c0 + 11*t1, 1, "R4");

    // R3, R5: new setting restarts the interval
    c1 = c0 + 11*t1 + 100;
    gotoEdge(c1);
    rateSel = 2'b10;
    freqSel = 2'b01;
    expectAt(c1 + t2 - 1, 1, "R5");
    expectAt(c1 + t2, 2, "R3");

    // R5: frequency change part way through an interval
    c2 = c1 + t2 + 700;
    gotoEdge(c2);
    freqSel = 2'b10;
    expectAt(c2 + t3 - 1, 2, "R5");
    expectAt(c2 + t3, 3, "R5");

    // R3: 125 us with frequency code 11
    c3 = c2 + t3 + 50;
    gotoEdge(c3);
    rateSel = 2'b11;
    freqSel = 2'b11;
    expectAt(c3 + t4 - 1, 3, "R3");
    expectAt(c3 + t4, 4, "R3");

    // R2: turning refresh off keeps the pending count and adds nothing
    c4 = c3 + t4 + 10;
    gotoEdge(c4);
    rateSel = 2'b00;
    expectAt(c4 + t4 + 400, 4, "R2");

    while (q.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule